// File: doc/BRIEF.md
# Switching Activity Counter

This block watches a wide bank of state registers presented as one flat snapshot bus and measures, for every accepted snapshot, how many bits differ from the snapshot accepted before it. That count is the Hamming distance between consecutive values. It is summed over a selectable subset of the registers. At the same time the block reports the distance inside a few individually selected bytes. The result is a per-cycle switching-activity trace of the kind a power model needs, produced in hardware next to the logic being observed.

Work is organised in fixed-length windows. A start pulse arms the block. The first valid snapshot after it becomes the baseline, and each of the following `WINDOW` valid snapshots produces one count tagged with its index. While the window runs the block keeps the largest total seen so far. One cycle after the last count it pulses a done flag. Counts leave through a four-stage pipeline (XOR, byte popcount, per-register sum, total), so the latency is fixed.

Top module: `swc_activity_counter`

## Requirements
- R1: While `rst_ni` is low, `cnt_valid_o`, `done_o`, `total_o`, `peak_o` and `cycle_idx_o` are all zero, and they return to zero whenever reset is applied mid-window.
- R2: For each count, `total_o` equals the sum of the bit differences between the current and previous accepted snapshot over the enabled registers. It ranges from 0 to `NUM_REGS*REG_W` (1536 by default), which is reached when every bit of every enabled register toggles.
- R3: Register r occupies `snap_i[r*REG_W +: REG_W]`, and bit r of `reg_mask_i` enables it. A register whose bit is clear adds nothing. The mask is sampled in the same cycle as the snapshot it applies to.
- R4: Slice k reports on `slice_cnt_o[4k +: 4]` the bit differences, from 0 to 8, of byte b = `slice_sel_i[k*SEL_W +: SEL_W]`, where byte b is `snap_i[8b +: 8]`. Slices ignore `reg_mask_i`, and a select of `NUM_REGS*REG_W/8` (192) or more reports 0.
- R5: The snapshot presented in the cycle that `start_i` is high is ignored. The first valid snapshot after the start pulse becomes the baseline and produces no count.
- R6: A cycle with `valid_i` low produces no count and leaves the stored previous value unchanged, whatever `snap_i` holds.
- R7: Each window yields exactly `WINDOW` (52) counts, with `cycle_idx_o` running 0 to `WINDOW-1` in order. Valid snapshots after the last count are ignored until the next start.
- R8: A snapshot accepted at clock edge n produces its count on the outputs after edge n+3.
- R9: `peak_o` holds the largest `total_o` emitted so far in the current window, updated together with `total_o`, and cleared by `start_i`.
- R10: `done_o` is high for exactly one cycle, the cycle right after the count with index `WINDOW-1`.
- R11: A start pulse during a window discards every count still in the pipeline. The cycle after the pulse shows no count, and a fresh window begins at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new window and aborts any running one |
| valid_i | input | 1 | Snapshot on `snap_i` is valid this cycle |
| snap_i | input | NUM_REGS*REG_W | Flat snapshot of all monitored registers |
| reg_mask_i | input | NUM_REGS | Per-register enable for the total |
| slice_sel_i | input | NUM_SLICES*SEL_W | Byte index selected for each slice |
| cnt_valid_o | output | 1 | A count is present this cycle |
| total_o | output | $clog2(NUM_REGS*REG_W+1) | Masked Hamming distance total |
| slice_cnt_o | output | NUM_SLICES*4 | Per-slice byte Hamming distance |
| cycle_idx_o | output | $clog2(WINDOW) | Index of the count within the window |
| peak_o | output | $clog2(NUM_REGS*REG_W+1) | Running maximum of the total in the window |
| done_o | output | 1 | One-cycle pulse after the last count |

## Verification
The bench builds the block with its defaults: twelve 128-bit registers, a 52-count window and four slices. With these values the full-scale total of 1536 can be reached, by alternating all-zero and all-one snapshots with every register enabled. One slice is pointed at byte 191, the top byte of the bus, and another at code 200, so both the last legal byte and the unused select codes from 192 to 255 are exercised. A window length of 52 keeps both index boundaries, the baseline sample and the count at index 51, within a few hundred cycles per window across eight stimulus patterns. The remaining cases are an aborted window and a mid-window reset.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE,
    WIN_BASE,
    WIN_RUN
  } win_state_e;

  function automatic logic [3:0] pop8(input logic [7:0] b);
    logic [3:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) c = c + {3'b000, b[i]};
    return c;
  endfunction

endpackage

// File: rtl/swc_window_ctl.sv
module swc_window_ctl #(
  parameter int WINDOW = 52,
  localparam int IDX_W = $clog2(WINDOW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  output logic             load_o,
  output logic             issue_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WINDOW - 1);

  swc_pkg::win_state_e state_q;
  logic [IDX_W-1:0]    idx_q;

  // the start cycle itself never loads or counts
  assign load_o  = valid_i && !start_i && (state_q != swc_pkg::WIN_IDLE);
  assign issue_o = valid_i && !start_i && (state_q == swc_pkg::WIN_RUN);
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= swc_pkg::WIN_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= swc_pkg::WIN_BASE;
      idx_q   <= '0;
    end else if (valid_i) begin
      case (state_q)
        swc_pkg::WIN_BASE: state_q <= swc_pkg::WIN_RUN;
        swc_pkg::WIN_RUN: begin
          if (idx_q == LAST) begin
            state_q <= swc_pkg::WIN_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= swc_pkg::WIN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swc_byte_pop.sv
module swc_byte_pop #(
  parameter int NUM_BYTES = 192
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_BYTES*8-1:0] diff_i,
  output logic [NUM_BYTES*4-1:0] byte_cnt_o
);
  logic [3:0] cnt_q [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[b] <= '0;
      else         cnt_q[b] <= swc_pkg::pop8(diff_i[b*8 +: 8]);
    end
    assign byte_cnt_o[b*4 +: 4] = cnt_q[b];
  end
endmodule

// File: rtl/swc_reg_sum.sv
module swc_reg_sum #(
  parameter int NUM_REGS     = 12,
  parameter int BYTES_PER_RG = 16,
  parameter int CNT_W        = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_REGS*BYTES_PER_RG*4-1:0]  byte_cnt_i,
  input  logic [NUM_REGS-1:0]                 mask_i,
  output logic [NUM_REGS*CNT_W-1:0]           reg_cnt_o
);
  logic [CNT_W-1:0] cnt_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int b = 0; b < BYTES_PER_RG; b++)
        acc = acc + CNT_W'(byte_cnt_i[(r*BYTES_PER_RG+b)*4 +: 4]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[r] <= '0;
      else         cnt_q[r] <= mask_i[r] ? acc : '0;
    end
    assign reg_cnt_o[r*CNT_W +: CNT_W] = cnt_q[r];
  end
endmodule

// File: rtl/swc_activity_counter.sv
module swc_activity_counter #(
  parameter int NUM_REGS   = 12,
  parameter int REG_W      = 128,
  parameter int WINDOW     = 52,
  parameter int NUM_SLICES = 4,
  localparam int BPR       = REG_W / 8,
  localparam int NUM_BYTES = NUM_REGS * BPR,
  localparam int SNAP_W    = NUM_REGS * REG_W,
  localparam int SEL_W     = $clog2(NUM_BYTES),
  localparam int RCNT_W    = $clog2(REG_W + 1),
  localparam int TOT_W     = $clog2(SNAP_W + 1),
  localparam int IDX_W     = $clog2(WINDOW)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        valid_i,
  input  logic [SNAP_W-1:0]           snap_i,
  input  logic [NUM_REGS-1:0]         reg_mask_i,
  input  logic [NUM_SLICES*SEL_W-1:0] slice_sel_i,
  output logic                        cnt_valid_o,
  output logic [TOT_W-1:0]            total_o,
  output logic [NUM_SLICES*4-1:0]     slice_cnt_o,
  output logic [IDX_W-1:0]            cycle_idx_o,
  output logic [TOT_W-1:0]            peak_o,
  output logic                        done_o
);
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(WINDOW - 1);
  localparam logic [SEL_W:0]   NB_LIM = (SEL_W+1)'(NUM_BYTES);

  logic                        load, issue;
  logic [IDX_W-1:0]            idx_now;
  logic [SNAP_W-1:0]           prev_q, diff_q;
  logic                        v_a, v_b, v_c, v_d;
  logic [IDX_W-1:0]            idx_a, idx_b, idx_c, idx_d;
  logic [NUM_REGS-1:0]         mask_a, mask_b;
  logic [NUM_SLICES*SEL_W-1:0] sel_a, sel_b;
  logic [NUM_BYTES*4-1:0]      byte_cnt;
  logic [NUM_REGS*RCNT_W-1:0]  reg_cnt;
  logic [3:0]                  slice_c [NUM_SLICES];
  logic [3:0]                  slice_d [NUM_SLICES];
  logic [TOT_W-1:0]            total_sum, total_q, peak_q;
  logic                        done_q;

  swc_window_ctl #(.WINDOW(WINDOW)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .load_o  (load),
    .issue_o (issue),
    .idx_o   (idx_now)
  );

  // stage A: previous value and XOR
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      diff_q <= '0;
    end else begin
      if (load)  prev_q <= snap_i;
      if (issue) diff_q <= snap_i ^ prev_q;
    end
  end

  // stage B: byte popcounts
  swc_byte_pop #(.NUM_BYTES(NUM_BYTES)) u_pop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .diff_i     (diff_q),
    .byte_cnt_o (byte_cnt)
  );

  // stage C: masked per-register sums and slice picks
  swc_reg_sum #(
    .NUM_REGS     (NUM_REGS),
    .BYTES_PER_RG (BPR),
    .CNT_W        (RCNT_W)
  ) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_cnt_i (byte_cnt),
    .mask_i     (mask_b),
    .reg_cnt_o  (reg_cnt)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic [SEL_W-1:0] sel;
    assign sel = sel_b[k*SEL_W +: SEL_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slice_c[k] <= '0;
        slice_d[k] <= '0;
      end else begin
        slice_c[k] <= ({1'b0, sel} < NB_LIM) ? byte_cnt[{sel, 2'b00} +: 4] : 4'd0;
        slice_d[k] <= slice_c[k];
      end
    end
    assign slice_cnt_o[k*4 +: 4] = slice_d[k];
  end

  // stage D: total
  always_comb begin
    total_sum = '0;
    for (int r = 0; r < NUM_REGS; r++)
      total_sum = total_sum + TOT_W'(reg_cnt[r*RCNT_W +: RCNT_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {v_a, v_b, v_c, v_d} <= '0;
      {idx_a, idx_b, idx_c, idx_d} <= '0;
      mask_a  <= '0;
      mask_b  <= '0;
      sel_a   <= '0;
      sel_b   <= '0;
      total_q <= '0;
      peak_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      idx_a   <= idx_now;
      idx_b   <= idx_a;
      idx_c   <= idx_b;
      idx_d   <= idx_c;
      mask_a  <= reg_mask_i;
      mask_b  <= mask_a;
      sel_a   <= slice_sel_i;
      sel_b   <= sel_a;
      total_q <= total_sum;
      if (start_i) begin
        // abort flushes everything in flight
        {v_a, v_b, v_c, v_d} <= '0;
        peak_q <= '0;
        done_q <= 1'b0;
      end else begin
        v_a    <= issue;
        v_b    <= v_a;
        v_c    <= v_b;
        v_d    <= v_c;
        done_q <= v_d && (idx_d == LAST);
        if (v_c && (total_sum > peak_q)) peak_q <= total_sum;
      end
    end
  end

  assign cnt_valid_o = v_d;
  assign total_o     = total_q;
  assign cycle_idx_o = idx_d;
  assign peak_o      = peak_q;
  assign done_o      = done_q;
endmodule

// File: rtl/swc_activity_counter_chk.sv
module swc_activity_counter_chk #(
  parameter int NUM_REGS   = 12,
  parameter int REG_W      = 128,
  parameter int WINDOW     = 52,
  parameter int NUM_SLICES = 4,
  localparam int SNAP_W    = NUM_REGS * REG_W,
  localparam int SEL_W     = $clog2(NUM_REGS * REG_W / 8),
  localparam int TOT_W     = $clog2(SNAP_W + 1),
  localparam int IDX_W     = $clog2(WINDOW)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic                        valid_i,
  input logic [SNAP_W-1:0]           snap_i,
  input logic [NUM_REGS-1:0]         reg_mask_i,
  input logic [NUM_SLICES*SEL_W-1:0] slice_sel_i,
  input logic                        cnt_valid_o,
  input logic [TOT_W-1:0]            total_o,
  input logic [NUM_SLICES*4-1:0]     slice_cnt_o,
  input logic [IDX_W-1:0]            cycle_idx_o,
  input logic [TOT_W-1:0]            peak_o,
  input logic                        done_o
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(WINDOW - 1);
  localparam logic [TOT_W-1:0] TOPV  = TOT_W'(SNAP_W);

  assert_total_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_valid_o |-> total_o <= TOPV);

  assert_idx_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_valid_o |-> cycle_idx_o <= LAST);

  assert_peak_covers_total_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_valid_o |-> peak_o >= total_o);

  assert_done_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cnt_valid_o) && ($past(cycle_idx_o) == LAST));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_flushes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !cnt_valid_o && !done_o);

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_sl
    assert_slice_le8_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_valid_o |-> slice_cnt_o[k*4 +: 4] <= 4'd8);
  end
endmodule

bind swc_activity_counter swc_activity_counter_chk #(
  .NUM_REGS   (NUM_REGS),
  .REG_W      (REG_W),
  .WINDOW     (WINDOW),
  .NUM_SLICES (NUM_SLICES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .valid_i     (valid_i),
  .snap_i      (snap_i),
  .reg_mask_i  (reg_mask_i),
  .slice_sel_i (slice_sel_i),
  .cnt_valid_o (cnt_valid_o),
  .total_o     (total_o),
  .slice_cnt_o (slice_cnt_o),
  .cycle_idx_o (cycle_idx_o),
  .peak_o      (peak_o),
  .done_o      (done_o)
);

// File: tb/swc_activity_counter_test.sv
`timescale 1ns/1ps
module swc_activity_counter_test;
  localparam int NUM_REGS   = 12;
  localparam int REG_W      = 128;
  localparam int WINDOW     = 52;
  localparam int NUM_SLICES = 4;
  localparam int SNAP_W     = NUM_REGS * REG_W;
  localparam int NUM_BYTES  = SNAP_W / 8;
  localparam int SEL_W      = $clog2(NUM_BYTES);
  localparam int TOT_W      = $clog2(SNAP_W + 1);
  localparam int IDX_W      = $clog2(WINDOW);
  localparam logic [NUM_SLICES*SEL_W-1:0] SEL_CFG = {8'd200, 8'd191, 8'd17, 8'd0};

  // {mode[3:0], mask[11:0]}; mode 0 hashed with gaps, 1 all-toggle, 2 constant, 3 walking bit
  localparam logic [15:0] VEC [8] = '{16'h0FFF, 16'h1FFF, 16'h1000, 16'h00A5,
                                      16'h2FFF, 16'h3801, 16'h0F0F, 16'h1001};

  logic                        clk = 1'b0;
  logic                        rst_ni = 1'b0;
  logic                        start_i = 1'b0;
  logic                        valid_i = 1'b0;
  logic [SNAP_W-1:0]           snap_i = '0;
  logic [NUM_REGS-1:0]         reg_mask_i = '0;
  logic [NUM_SLICES*SEL_W-1:0] slice_sel_i = SEL_CFG;
  logic                        cnt_valid_o;
  logic [TOT_W-1:0]            total_o;
  logic [NUM_SLICES*4-1:0]     slice_cnt_o;
  logic [IDX_W-1:0]            cycle_idx_o;
  logic [TOT_W-1:0]            peak_o;
  logic                        done_o;

  swc_activity_counter uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .valid_i     (valid_i),
    .snap_i      (snap_i),
    .reg_mask_i  (reg_mask_i),
    .slice_sel_i (slice_sel_i),
    .cnt_valid_o (cnt_valid_o),
    .total_o     (total_o),
    .slice_cnt_o (slice_cnt_o),
    .cycle_idx_o (cycle_idx_o),
    .peak_o      (peak_o),
    .done_o      (done_o)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int cnt_seen = 0;
  int done_seen = 0;
  int mi;
  int exp_total [WINDOW];
  int exp_peak  [WINDOW];
  int exp_cyc   [WINDOW];
  int exp_slice [WINDOW][NUM_SLICES];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [SNAP_W-1:0] gen(input int mode, input int j, input int seed);
    logic [SNAP_W-1:0] g;
    logic [31:0] x;
    g = '0;
    case (mode)
      0: for (int w = 0; w < SNAP_W/32; w++) begin
           x = (32'(j) * 32'h9E3779B1) + (32'(w) * 32'h85EBCA6B) + 32'(seed);
           x = x ^ (x >> 15);
           x = x * 32'h2C1B3C6D;
           x = x ^ (x >> 12);
           g[w*32 +: 32] = x;
         end
      1: g = (j % 2 == 1) ? '1 : '0;
      2: g = {(SNAP_W/8){8'h5A}};
      default: for (int r = 0; r < NUM_REGS; r++) g[r*REG_W + (j % REG_W)] = 1'b1;
    endcase
    return g;
  endfunction

  function automatic int hd_total(input logic [SNAP_W-1:0] d, input logic [NUM_REGS-1:0] m);
    int t = 0;
    for (int r = 0; r < NUM_REGS; r++) if (m[r]) t += $countones(d[r*REG_W +: REG_W]);
    return t;
  endfunction

  function automatic int hd_byte(input logic [SNAP_W-1:0] d, input int sel);
    if (sel >= NUM_BYTES) return 0;
    return $countones(d[sel*8 +: 8]);
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cnt_valid_o) begin
        mi = int'(cycle_idx_o);
        check(mi == cnt_seen, "R7 index order", mi, cnt_seen);
        if (mi < WINDOW) begin
          check(int'(total_o) == exp_total[mi], "R2 R3 R5 R6 total", int'(total_o), exp_total[mi]);
          for (int k = 0; k < NUM_SLICES; k++)
            check(int'(slice_cnt_o[k*4 +: 4]) == exp_slice[mi][k], "R4 slice",
                  int'(slice_cnt_o[k*4 +: 4]), exp_slice[mi][k]);
          check(cyc == exp_cyc[mi], "R8 latency", cyc, exp_cyc[mi]);
          check(int'(peak_o) == exp_peak[mi], "R9 running peak", int'(peak_o), exp_peak[mi]);
        end
        cnt_seen++;
      end
      if (done_o) begin
        check(cnt_seen == WINDOW, "R10 done after last count", cnt_seen, WINDOW);
        check(cyc == exp_cyc[WINDOW-1] + 1, "R10 done timing", cyc, exp_cyc[WINDOW-1] + 1);
        done_seen++;
      end
    end
  end

  task automatic run_window(input int mode, input logic [NUM_REGS-1:0] mask, input int abort_after);
    logic [SNAP_W-1:0] prev, cur, d;
    int runmax;
    prev = '0;
    @(negedge clk);
    start_i = 1'b1; valid_i = 1'b1; snap_i = gen(0, 7, 999); reg_mask_i = mask;
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
    check(!cnt_valid_o && !done_o, "R11 no count after start", int'(cnt_valid_o), 0);
    cnt_seen = 0; done_seen = 0; runmax = 0;
    for (int j = 0; j <= WINDOW; j++) begin
      if (mode == 0 && j % 4 == 2) begin
        valid_i = 1'b0; snap_i = gen(0, j, 4242); reg_mask_i = ~mask;  // R6 gap
        @(negedge clk);
      end
      cur = gen(mode, j, mode * 1000 + int'(mask));
      snap_i = cur; valid_i = 1'b1; reg_mask_i = mask;
      if (j > 0) begin
        d = cur ^ prev;
        exp_total[j-1] = hd_total(d, mask);
        for (int k = 0; k < NUM_SLICES; k++)
          exp_slice[j-1][k] = hd_byte(d, int'(SEL_CFG[k*SEL_W +: SEL_W]));
        if (exp_total[j-1] > runmax) runmax = exp_total[j-1];
        exp_peak[j-1] = runmax;
        exp_cyc[j-1] = cyc + 4;
      end
      prev = cur;
      @(negedge clk);
      if (abort_after != 0 && j == abort_after) begin
        valid_i = 1'b0;
        return;
      end
    end
    for (int k = 0; k < 3; k++) begin  // R7: beyond the window
      snap_i = gen(0, k, 777); valid_i = 1'b1;
      @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (8) @(negedge clk);
    check(cnt_seen == WINDOW, "R7 counts per window", cnt_seen, WINDOW);
    check(done_seen == 1, "R10 single done pulse", done_seen, 1);
    check(int'(peak_o) == runmax, "R9 final peak", int'(peak_o), runmax);
  endtask

  initial begin
    #(4 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!cnt_valid_o && !done_o, "R1 reset flags", int'(cnt_valid_o) + int'(done_o), 0);
    check(total_o == '0 && peak_o == '0, "R1 reset counts", int'(total_o) + int'(peak_o), 0);
    check(cycle_idx_o == '0, "R1 reset index", int'(cycle_idx_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 8; v++)
      run_window(int'(VEC[v][15:12]), VEC[v][11:0], 0);

    // R11: abort mid-window, then a clean window must follow
    run_window(0, 12'hFFF, 10);
    run_window(1, 12'hFFF, 0);

    // R1: reset in the middle of a window
    run_window(1, 12'hFFF, 20);
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(!cnt_valid_o && !done_o, "R1 mid-window reset flags", int'(cnt_valid_o), 0);
    check(total_o == '0 && peak_o == '0, "R1 mid-window reset counts", int'(peak_o), 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    check(!cnt_valid_o, "R1 idle after reset", int'(cnt_valid_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule